// File: doc/BRIEF.md
# Instruction Fetch Permission Checker

This unit sits behind first-stage address translation and rules on each instruction fetch. It combines the access-permission bits of the final descriptor, the two execute-never bits (one for privileged and one for unprivileged code), the privilege level of the fetch and one system-control bit. That control bit, write-implies-no-execute, makes writable memory non-executable. The result is either a grant or an instruction abort. An abort carries a 6-bit exception class and a 6-bit fault status code.

Requests arrive with a valid/ready handshake. The verdict comes out of a single response register, one cycle after the request is accepted, under its own valid/ready pair. When the consumer stalls, the response is held and new requests are refused. The control word has the full system-register width, and only the configured bit position is decoded.

Top module: `ifpc_fetch_checker`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid_o is 0 and req_ready_o is 1 until a request is accepted.
- R2: With the control bit (sysctl_i bit 19) at 0, an unprivileged fetch (req_el_i == 0) is denied exactly when req_xn_user_i is 1. A privileged fetch (req_el_i != 0) is denied exactly when req_xn_priv_i is 1.
- R3: With the control bit at 1, an unprivileged fetch to a region with req_ap_ro_i == 0 and req_ap_user_i == 1 (writable by unprivileged code) is denied, whatever req_xn_user_i is.
- R4: With the control bit at 1, a privileged fetch to a region with req_ap_ro_i == 0 is denied, whatever req_xn_priv_i is.
- R5: With the control bit at 1, an unprivileged fetch to a region with req_ap_ro_i == 0 and req_ap_user_i == 0 follows req_xn_user_i only.
- R6: With the control bit at 1, a fetch to a read-only region (req_ap_ro_i == 1) follows the descriptor execute-never bit for its privilege only.
- R7: A denied privileged fetch reports rsp_ec_o = 6'b100001. A denied unprivileged fetch reports rsp_ec_o = 6'b100000.
- R8: A denied fetch reports rsp_fsc_o = {4'b0011, req_lvl_i}, so a level-3 fault gives 6'b001111.
- R9: A granted fetch reports rsp_grant_o = 1 with rsp_ec_o and rsp_fsc_o both zero.
- R10: The response is valid on the cycle after acceptance. While rsp_valid_o is 1 and rsp_ready_i is 0, the response stays unchanged and req_ready_o is 0.
- R11: Bits of sysctl_i other than bit 19 have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_el_i | input | EL_W | Privilege level of the fetch, 0 = unprivileged |
| req_lvl_i | input | 2 | Translation level of the final descriptor |
| req_ap_ro_i | input | 1 | Descriptor read-only bit (0 = writable) |
| req_ap_user_i | input | 1 | Descriptor unprivileged-access bit |
| req_xn_priv_i | input | 1 | Descriptor privileged execute-never |
| req_xn_user_i | input | 1 | Descriptor unprivileged execute-never |
| sysctl_i | input | CTRL_W | System control word |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_grant_o | output | 1 | Fetch permitted |
| rsp_ec_o | output | 6 | Exception class on abort, else 0 |
| rsp_fsc_o | output | 6 | Fault status code on abort, else 0 |

## Verification
The bench builds the block with its defaults: a 64-bit control word with the override at bit 19, and a 2-bit privilege level. With that width the bench can set every other control bit and show that none of them matters. With the 2-bit level it drives levels 0 and 2, which separate the unprivileged path from a privileged path that is not level 1. A sweep covers every combination of descriptor bits, override and privilege, and rotates through all four translation levels to exercise the status code. A separate scenario stalls the consumer and checks that the response is held.

// File: rtl/ifpc_pkg.sv
package ifpc_pkg;
  localparam int unsigned CODE_W = 6;
  localparam logic [CODE_W-1:0] EC_ABORT_SAME  = 6'b100001;
  localparam logic [CODE_W-1:0] EC_ABORT_LOWER = 6'b100000;
  localparam logic [3:0]        FSC_PERM_PFX   = 4'b0011;

  typedef struct packed {
    logic              grant;
    logic [CODE_W-1:0] ec;
    logic [CODE_W-1:0] fsc;
  } ifpc_rsp_t;
endpackage

// File: rtl/ifpc_eff_xn.sv
module ifpc_eff_xn (
  input  logic wne_i,
  input  logic ap_ro_i,
  input  logic ap_user_i,
  input  logic xn_priv_i,
  input  logic xn_user_i,
  output logic eff_xn_priv_o,
  output logic eff_xn_user_o
);
  logic wr_priv, wr_user;

  always_comb begin
    wr_priv       = !ap_ro_i;
    wr_user       = !ap_ro_i && ap_user_i;
    eff_xn_priv_o = xn_priv_i || (wne_i && wr_priv);
    eff_xn_user_o = xn_user_i || (wne_i && wr_user);
  end
endmodule

// File: rtl/ifpc_fault_enc.sv
module ifpc_fault_enc
  import ifpc_pkg::*;
(
  input  logic       is_priv_i,
  input  logic       eff_xn_priv_i,
  input  logic       eff_xn_user_i,
  input  logic [1:0] lvl_i,
  output ifpc_rsp_t  rsp_o
);
  logic deny;

  always_comb begin
    deny = is_priv_i ? eff_xn_priv_i : eff_xn_user_i;
    rsp_o.grant = !deny;
    rsp_o.ec    = '0;
    rsp_o.fsc   = '0;
    if (deny) begin
      rsp_o.ec  = is_priv_i ? EC_ABORT_SAME : EC_ABORT_LOWER;
      rsp_o.fsc = {FSC_PERM_PFX, lvl_i};
    end
  end
endmodule

// File: rtl/ifpc_fetch_checker.sv
module ifpc_fetch_checker
  import ifpc_pkg::*;
#(
  parameter int unsigned CTRL_W  = 64,
  parameter int unsigned WNE_BIT = 19,
  parameter int unsigned EL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [EL_W-1:0]   req_el_i,
  input  logic [1:0]        req_lvl_i,
  input  logic              req_ap_ro_i,
  input  logic              req_ap_user_i,
  input  logic              req_xn_priv_i,
  input  logic              req_xn_user_i,
  input  logic [CTRL_W-1:0] sysctl_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_grant_o,
  output logic [CODE_W-1:0] rsp_ec_o,
  output logic [CODE_W-1:0] rsp_fsc_o
);
  localparam int unsigned HI_W = CTRL_W - WNE_BIT - 1;

  logic      wne, is_priv, accept;
  logic      eff_xn_priv, eff_xn_user;
  ifpc_rsp_t rsp_d, rsp_q;
  logic      rsp_vld_q;

  assign wne     = sysctl_i[WNE_BIT];
  assign is_priv = |req_el_i;

  // remaining control bits are deliberately not decoded
  generate
    if (WNE_BIT > 0 && HI_W > 0) begin : g_unused_both
      logic ctl_unused;
      assign ctl_unused = ^{sysctl_i[CTRL_W-1:WNE_BIT+1], sysctl_i[WNE_BIT-1:0]};
    end else if (WNE_BIT > 0) begin : g_unused_lo
      logic ctl_unused;
      assign ctl_unused = ^sysctl_i[WNE_BIT-1:0];
    end else if (HI_W > 0) begin : g_unused_hi
      logic ctl_unused;
      assign ctl_unused = ^sysctl_i[CTRL_W-1:WNE_BIT+1];
    end
  endgenerate

  ifpc_eff_xn u_eff_xn (
    .wne_i        (wne),
    .ap_ro_i      (req_ap_ro_i),
    .ap_user_i    (req_ap_user_i),
    .xn_priv_i    (req_xn_priv_i),
    .xn_user_i    (req_xn_user_i),
    .eff_xn_priv_o(eff_xn_priv),
    .eff_xn_user_o(eff_xn_user)
  );

  ifpc_fault_enc u_fault_enc (
    .is_priv_i    (is_priv),
    .eff_xn_priv_i(eff_xn_priv),
    .eff_xn_user_i(eff_xn_user),
    .lvl_i        (req_lvl_i),
    .rsp_o        (rsp_d)
  );

  assign req_ready_o = !rsp_vld_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_q <= 1'b0;
      rsp_q     <= '0;
    end else if (accept) begin
      rsp_vld_q <= 1'b1;
      rsp_q     <= rsp_d;
    end else if (rsp_ready_i) begin
      rsp_vld_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_vld_q;
  assign rsp_grant_o = rsp_vld_q && rsp_q.grant;
  assign rsp_ec_o    = rsp_q.ec;
  assign rsp_fsc_o   = rsp_q.fsc;

  AST_ACCEPT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o); // R10
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable({rsp_grant_o, rsp_ec_o, rsp_fsc_o}))); // R10
  AST_GRANT_NO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_grant_o) |-> (rsp_ec_o == '0 && rsp_fsc_o == '0)); // R9
  AST_FSC_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_grant_o) |-> (rsp_fsc_o[5:2] == FSC_PERM_PFX)); // R8
  AST_EC_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_grant_o) |-> (rsp_ec_o == EC_ABORT_SAME || rsp_ec_o == EC_ABORT_LOWER)); // R7
  AST_USER_WNE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wne && !req_ap_ro_i && req_ap_user_i && !is_priv) |=> !rsp_grant_o); // R3
  AST_PRIV_WNE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wne && !req_ap_ro_i && is_priv) |=> !rsp_grant_o); // R4
endmodule

// File: tb/ifpc_fetch_checker_test.sv
`timescale 1ns/1ps
module ifpc_fetch_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_el = '0, req_lvl = '0;
  logic        ap_ro = 1'b0, ap_user = 1'b0, xn_p = 1'b0, xn_u = 1'b0;
  logic [63:0] sysctl = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_grant;
  logic [5:0]  rsp_ec, rsp_fsc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ifpc_fetch_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_el_i(req_el), .req_lvl_i(req_lvl), .req_ap_ro_i(ap_ro), .req_ap_user_i(ap_user),
    .req_xn_priv_i(xn_p), .req_xn_user_i(xn_u), .sysctl_i(sysctl),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_grant_o(rsp_grant),
    .rsp_ec_o(rsp_ec), .rsp_fsc_o(rsp_fsc));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] el, input logic [1:0] lvl, input bit ro, input bit usr,
                       input bit xp, input bit xu, input logic [63:0] ctl);
    req_el = el; req_lvl = lvl; ap_ro = ro; ap_user = usr; xn_p = xp; xn_u = xu; sysctl = ctl;
  endtask

  task automatic test_reset();
    #1;
    chk(rsp_valid == 1'b0, "R1 valid in reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid after reset", rsp_valid, 0);
  endtask

  // one accepted request, response checked on the next cycle
  task automatic fetch_one(input logic [1:0] el, input logic [1:0] lvl, input bit ro, input bit usr,
                           input bit xp, input bit xu, input logic [63:0] ctl, input string tag);
    bit wne, priv, exu, exp_, deny;
    logic [5:0] eec, efsc;
    wne  = ctl[19];
    priv = (el != 0);
    exu  = xu | (wne & !ro & usr);
    exp_ = xp | (wne & !ro);
    deny = priv ? exp_ : exu;
    eec  = deny ? (priv ? 6'b100001 : 6'b100000) : 6'b0;
    efsc = deny ? {4'b0011, lvl} : 6'b0;
    @(negedge clk);
    drive(el, lvl, ro, usr, xp, xu, ctl);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R10 valid"}, rsp_valid, 1);
    chk(rsp_grant == !deny, tag, rsp_grant, !deny);
    chk(rsp_ec == eec, deny ? "R7 class" : "R9 class", rsp_ec, eec);
    chk(rsp_fsc == efsc, deny ? "R8 status" : "R9 status", rsp_fsc, efsc);
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 64; i++) begin
      logic [1:0] el;
      bit ro, usr, xp, xu, w;
      string tag;
      el = i[0] ? 2'd2 : 2'd0;
      ro = i[1]; usr = i[2]; xp = i[3]; xu = i[4]; w = i[5];
      if (!w)              tag = "R2";
      else if (ro)         tag = "R6";
      else if (el != 0)    tag = "R4";
      else if (usr)        tag = "R3";
      else                 tag = "R5";
      fetch_one(el, 2'(i + (i >> 2)), ro, usr, xp, xu, w ? 64'h0008_0000 : 64'h0, tag);
    end
    fetch_one(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0008_0000, "R4 level3");
    chk(rsp_fsc == 6'b001111, "R8 level3 code", rsp_fsc, 6'b001111);
  endtask

  task automatic test_ctl_bits();
    fetch_one(2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, ~64'h0008_0000, "R11 others set");
    fetch_one(2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, ~64'h0008_0000, "R11 others set priv");
    fetch_one(2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0008_0000, "R11 only bit19");
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0008_0000);
    req_valid = 1'b1;
    @(negedge clk);
    drive(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0);
    chk(rsp_valid == 1'b1, "R10 valid stall", rsp_valid, 1);
    chk(req_ready == 1'b0, "R10 ready low", req_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !rsp_grant && rsp_ec == 6'b100001 && rsp_fsc == 6'b001110,
          "R10 held", {rsp_valid, rsp_grant, rsp_ec, rsp_fsc}, {1'b1, 1'b0, 6'b100001, 6'b001110});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_grant, "R10 next after drain", {rsp_valid, rsp_grant}, 2'b11);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 drained", rsp_valid, 0);
  endtask

  initial begin
    test_reset();
    test_sweep();
    test_ctl_bits();
    test_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule